// File: doc/BRIEF.md
# Doorbell Interrupt Register Bank

This block is a small memory-mapped slave with five 32-bit storage words and one level-sensitive interrupt line to the processor. Two words hold descriptor data, one holds configuration, one holds event status, and one is a software-interrupt word that software changes only through a set window and a clear window. The interrupt line is not computed from an enable mask. It is a sticky flag that certain writes turn on or off, depending on the window written and on particular bits of the written data.

The bus side accepts one request per cycle on a valid/ready pair, with word-only accesses. Every accepted request gets a one-cycle response pulse. For a read, the pulse carries the read data. For a write, the pulse carries zero. Driver software uses the block as a doorbell: it posts a descriptor whose doorbell bit is set, or writes the set window, to raise the line. The interrupt handler then acknowledges through the configuration, status or clear windows.

Top module: `irq_regbank`

## Requirements
- R1: After reset, all five storage words are zero, `irq_o` is low and `rsp_valid` is low.
- R2: `req_ready` is always high. Each accepted request produces `rsp_valid` high exactly one cycle later. For a read, `rsp_rdata` then carries the read data. For a write, `rsp_rdata` is zero.
- R3: The descriptor words at byte offsets 0x28 and 0x2C and the status word at 0x50 store all 32 written bits and read back unchanged.
- R4: The configuration word at offset 0x4C stores all 32 bits. Its read value always has bit 17 set to 1, whatever was written.
- R5: A write to offset 0x2C with data bit 29 set drives `irq_o` high from the next cycle. With bit 29 clear, `irq_o` keeps its value.
- R6: A write to offset 0x4C with data bit 16 set drives `irq_o` low from the next cycle. With bit 16 clear, `irq_o` keeps its value.
- R7: A write to offset 0x50 with data bit 16 or bit 29 set drives `irq_o` low from the next cycle. With both bits clear, `irq_o` keeps its value.
- R8: A write to offset 0x1F0 ORs the data into the software-interrupt word and drives `irq_o` high, even when the data is zero.
- R9: A write to offset 0x1F4 clears the software-interrupt bits that are 1 in the data and drives `irq_o` low, even when the data is zero.
- R10: A read of offset 0x1F0 or offset 0x1F4 returns the current software-interrupt word.
- R11: An address that matches none of the six offsets is treated as unknown. This includes any address whose low two bits are not zero. A write to an unknown address changes no stored word and leaves `irq_o` unchanged. A read of an unknown address returns zero.
- R12: A write to offset 0x28 never changes `irq_o`, whatever the data bits are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response pulse, one cycle after acceptance |
| rsp_rdata | output | 32 | Read data, zero for writes |
| irq_o | output | 1 | Level-sensitive interrupt line |

## Verification
The doorbell, acknowledge and set/clear windows are each written twice: once with the trigger bit set and once with it clear, or with zero data for the set and clear windows. This shows whether the line is driven by the data bit or by the address alone. Trigger bits are also written to the windows that must ignore them: bit 29 to the first descriptor, and bit 29 to an unknown or misaligned address while the line is low. This catches decoders that match too broadly. Both status acknowledge bits are tried one at a time, so a design that decodes only one of them is caught. Configuration reads follow writes with bit 17 both clear and set, which separates the forced read-back bit from the stored one.

// File: rtl/irqbank_pkg.sv
package irqbank_pkg;

    localparam int DATA_W    = 32;
    localparam int NUM_SLOTS = 6;

    // slot indices (one per decoded word address)
    localparam int SLOT_DSC0 = 0;
    localparam int SLOT_DSC1 = 1;
    localparam int SLOT_CFG  = 2;
    localparam int SLOT_EVT  = 3;
    localparam int SLOT_SWS  = 4;
    localparam int SLOT_SWC  = 5;

    // data bits with side effects on the interrupt line
    localparam int BIT_DOORBELL = 29;
    localparam int BIT_ACK_LO   = 16;
    localparam int BIT_ACK_HI   = 29;
    localparam int BIT_CFG_ONE  = 17;

    function automatic int unsigned slot_offset(input int idx);
        case (idx)
            SLOT_DSC0: slot_offset = 32'h028;
            SLOT_DSC1: slot_offset = 32'h02C;
            SLOT_CFG:  slot_offset = 32'h04C;
            SLOT_EVT:  slot_offset = 32'h050;
            SLOT_SWS:  slot_offset = 32'h1F0;
            default:   slot_offset = 32'h1F4;
        endcase
    endfunction

    typedef struct packed {
        logic [DATA_W-1:0] dsc0;
        logic [DATA_W-1:0] dsc1;
        logic [DATA_W-1:0] cfg;
        logic [DATA_W-1:0] evt;
        logic [DATA_W-1:0] swi;
        logic              irq;
        logic              rsp_valid;
        logic [DATA_W-1:0] rsp_rdata;
    } bank_state_t;

endpackage

// File: rtl/irqbank_decode.sv
module irqbank_decode
    import irqbank_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic [NUM_SLOTS-1:0] hit
);

    // one comparator per slot; misaligned addresses match nothing
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign hit[g] = (addr == ADDR_W'(slot_offset(g)));
    end

endmodule

// File: rtl/irqbank_irqact.sv
module irqbank_irqact
    import irqbank_pkg::*;
(
    input  logic                 wr_en,
    input  logic [NUM_SLOTS-1:0] hit,
    input  logic                 bit_lo,
    input  logic                 bit_hi,
    output logic                 raise,
    output logic                 lower
);

    always_comb begin
        raise = wr_en & ((hit[SLOT_DSC1] & bit_hi) | hit[SLOT_SWS]);
        lower = wr_en & ((hit[SLOT_CFG] & bit_lo)
                       | (hit[SLOT_EVT] & (bit_lo | bit_hi))
                       |  hit[SLOT_SWC]);
    end

endmodule

// File: rtl/irq_regbank.sv
module irq_regbank
    import irqbank_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              irq_o
);

    localparam logic [DATA_W-1:0] CFG_FORCE = DATA_W'(1) << BIT_CFG_ONE;

    bank_state_t          st_d, st_q;
    logic [NUM_SLOTS-1:0] hit;
    logic                 acc, wr_en, rd_en;
    logic                 raise, lower;
    logic [DATA_W-1:0]    rd_word;

    assign req_ready = 1'b1;
    assign acc       = req_valid & req_ready;
    assign wr_en     = acc & req_write;
    assign rd_en     = acc & ~req_write;

    irqbank_decode #(.ADDR_W(ADDR_W)) i_decode (
        .addr (req_addr),
        .hit  (hit)
    );

    irqbank_irqact i_irqact (
        .wr_en  (wr_en),
        .hit    (hit),
        .bit_lo (req_wdata[BIT_ACK_LO]),
        .bit_hi (req_wdata[BIT_DOORBELL]),
        .raise  (raise),
        .lower  (lower)
    );

    always_comb begin
        rd_word = '0;
        if (hit[SLOT_DSC0])                  rd_word = st_q.dsc0;
        if (hit[SLOT_DSC1])                  rd_word = st_q.dsc1;
        if (hit[SLOT_CFG])                   rd_word = st_q.cfg | CFG_FORCE;
        if (hit[SLOT_EVT])                   rd_word = st_q.evt;
        if (hit[SLOT_SWS] || hit[SLOT_SWC])  rd_word = st_q.swi;
    end

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = acc;
        st_d.rsp_rdata = rd_en ? rd_word : '0;
        if (wr_en) begin
            if (hit[SLOT_DSC0]) st_d.dsc0 = req_wdata;
            if (hit[SLOT_DSC1]) st_d.dsc1 = req_wdata;
            if (hit[SLOT_CFG])  st_d.cfg  = req_wdata;
            if (hit[SLOT_EVT])  st_d.evt  = req_wdata;
            if (hit[SLOT_SWS])  st_d.swi  = st_q.swi | req_wdata;
            if (hit[SLOT_SWC])  st_d.swi  = st_q.swi & ~req_wdata;
        end
        if (raise)      st_d.irq = 1'b1;
        else if (lower) st_d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rsp_valid;
    assign rsp_rdata = st_q.rsp_rdata;
    assign irq_o     = st_q.irq;

endmodule

// File: rtl/irqbank_chk.sv
module irqbank_chk
    import irqbank_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              wd_lo,
    input logic              wd_hi,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              irq_o
);

    logic acc, known;
    assign acc   = req_valid && req_ready;
    assign known = (req_addr == ADDR_W'(12'h028)) || (req_addr == ADDR_W'(12'h02C))
                || (req_addr == ADDR_W'(12'h04C)) || (req_addr == ADDR_W'(12'h050))
                || (req_addr == ADDR_W'(12'h1F0)) || (req_addr == ADDR_W'(12'h1F4));

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !rsp_valid);

    // R2
    write_rsp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_write |=> rsp_rdata == '0);

    // R4
    cfg_bit_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !req_write && req_addr == ADDR_W'(12'h04C) |=> rsp_rdata[BIT_CFG_ONE]);

    // R5
    doorbell_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_write && req_addr == ADDR_W'(12'h02C) && wd_hi |=> irq_o);

    // R6
    cfg_ack_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_write && req_addr == ADDR_W'(12'h04C) && wd_lo |=> !irq_o);

    // R7
    evt_ack_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_write && req_addr == ADDR_W'(12'h050) && (wd_lo || wd_hi) |=> !irq_o);

    // R8
    swi_set_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_write && req_addr == ADDR_W'(12'h1F0) |=> irq_o);

    // R9
    swi_clr_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_write && req_addr == ADDR_W'(12'h1F4) |=> !irq_o);

    // R11
    unknown_wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_write && !known |=> $stable(irq_o));

    // R11
    unknown_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !req_write && !known |=> rsp_rdata == '0);

    // R12
    dsc0_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_write && req_addr == ADDR_W'(12'h028) |=> $stable(irq_o));

endmodule

bind irq_regbank irqbank_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .wd_lo     (req_wdata[16]),
    .wd_hi     (req_wdata[29]),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .irq_o     (irq_o)
);

// File: tb/test_irq_regbank.sv
`timescale 1ns/1ps
module test_irq_regbank;

    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic          irq_o;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] exp_rd_q[$];
    logic        exp_irq_q[$];
    string       tag_q[$];

    // spec model
    logic [31:0] m_dsc0 = 0, m_dsc1 = 0, m_cfg = 0, m_evt = 0, m_swi = 0;
    logic        m_irq = 0;

    always #4 clk = ~clk;

    irq_regbank #(.ADDR_W(AW)) i_irq_regbank (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // driver: called right after a falling edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
        case (a)
            12'h028: m_dsc0 = d;
            12'h02C: begin m_dsc1 = d; if (d[29]) m_irq = 1; end
            12'h04C: begin m_cfg = d; if (d[16]) m_irq = 0; end
            12'h050: begin m_evt = d; if (d[16] || d[29]) m_irq = 0; end
            12'h1F0: begin m_swi = m_swi | d; m_irq = 1; end
            12'h1F4: begin m_swi = m_swi & ~d; m_irq = 0; end
            default: ;
        endcase
        exp_rd_q.push_back(32'h0);
        exp_irq_q.push_back(m_irq);
        tag_q.push_back(tag);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        logic [31:0] e;
        case (a)
            12'h028: e = m_dsc0;
            12'h02C: e = m_dsc1;
            12'h04C: e = m_cfg | 32'h0002_0000;
            12'h050: e = m_evt;
            12'h1F0, 12'h1F4: e = m_swi;
            default: e = 32'h0;
        endcase
        exp_rd_q.push_back(e);
        exp_irq_q.push_back(m_irq);
        tag_q.push_back(tag);
        req_valid = 1; req_write = 0; req_addr = a; req_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        req_valid = 0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_rd_q.size() == 0) begin
                check("R2 unexpected response", 32'h1, 32'h0);
            end else begin
                string t;
                logic [31:0] er;
                logic ei;
                t  = tag_q.pop_front();
                er = exp_rd_q.pop_front();
                ei = exp_irq_q.pop_front();
                check({t, " rdata"}, rsp_rdata, er);
                check({t, " irq"}, {31'h0, irq_o}, {31'h0, ei});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 irq", {31'h0, irq_o}, 32'h0);
        check("R1 rsp_valid", {31'h0, rsp_valid}, 32'h0);
        check("R2 ready", {31'h0, req_ready}, 32'h1);
        rst_n = 1;
        @(negedge clk);
        rd(12'h028, "R1 dsc0"); rd(12'h02C, "R1 dsc1"); rd(12'h050, "R1 evt");
        rd(12'h1F0, "R1 swi"); rd(12'h04C, "R4 cfg reset");
        // R12 / R3
        wr(12'h028, 32'hFFFF_FFFF, "R12 dsc0 all ones");
        rd(12'h028, "R3 dsc0");
        // R5
        wr(12'h02C, 32'h0000_1234, "R5 dsc1 no doorbell");
        rd(12'h02C, "R3 dsc1");
        wr(12'h02C, 32'h2000_0001, "R5 dsc1 doorbell");
        wr(12'h028, 32'h2000_0000, "R12 dsc0 bit29 while high");
        // R6 / R4
        wr(12'h04C, 32'h0000_00FF, "R6 cfg no ack");
        rd(12'h04C, "R4 cfg forced");
        wr(12'h04C, 32'h0001_0000, "R6 cfg ack");
        rd(12'h04C, "R4 cfg bit16");
        wr(12'h04C, 32'h0002_0000, "R4 cfg bit17 written");
        rd(12'h04C, "R4 cfg bit17 read");
        // R8 zero data still raises
        wr(12'h1F0, 32'h0, "R8 set zero");
        rd(12'h1F4, "R10 swi zero");
        // R7
        wr(12'h050, 32'h0000_0001, "R7 evt no ack");
        wr(12'h050, 32'h2000_0000, "R7 evt ack hi");
        wr(12'h1F0, 32'h0000_00A5, "R8 set a5");
        wr(12'h050, 32'h0001_0000, "R7 evt ack lo");
        rd(12'h050, "R3 evt");
        // R8 / R10 / R9
        wr(12'h1F0, 32'h0000_0F00, "R8 set f00");
        rd(12'h1F0, "R10 via set");
        rd(12'h1F4, "R10 via clr");
        wr(12'h1F4, 32'h0000_00A0, "R9 clr a0");
        rd(12'h1F0, "R9 swi after clr");
        wr(12'h1F0, 32'h0, "R8 raise again");
        wr(12'h1F4, 32'h0, "R9 clr zero lowers");
        // R11 unknown and misaligned
        wr(12'h1F0, 32'h0, "R8 raise for R11");
        wr(12'h100, 32'hFFFF_FFFF, "R11 unknown wr high");
        wr(12'h1F4, 32'h0, "R9 lower for R11");
        wr(12'h02D, 32'h2000_0000, "R11 misaligned doorbell");
        wr(12'h029, 32'h1234_5678, "R11 misaligned dsc0");
        rd(12'h02C, "R11 dsc1 untouched");
        rd(12'h028, "R11 dsc0 untouched");
        rd(12'h029, "R11 misaligned rd");
        rd(12'h100, "R11 unknown rd");
        // R2 back-to-back mixed
        wr(12'h050, 32'hCAFE_0000, "R2 b2b wr");
        rd(12'h050, "R2 b2b rd");
        rd(12'h1F0, "R2 b2b rd2");
        repeat (3) @(negedge clk);
        check("R2 queue drained", exp_rd_q.size(), 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule